// File: doc/BRIEF.md
# Rectangle Copy and Fill Engine

This block carries out one rectangle operation on a frame buffer each time its start input pulses. It has two operations. A copy moves a rectangle of pixels from a source position to a destination position. A fill paints a destination rectangle with a single colour. The operation, the pixel format, the corner coordinates, the size, and the pitch and base-address settings are all presented as plain input fields. These fields must stay steady while the engine is busy.

Memory is reached through a 32-bit word port. Reads return data one cycle after the request, and writes carry per-byte lane enables. The engine works one byte at a time. On a reversed axis it walks from the far corner, so a copy whose destination lies ahead of its source on that axis gives the same result as reading the whole source first.

Before any memory access, an operation is checked. An invalid operation is rejected with an error flag, and nothing in memory changes. Every operation ends with a one-cycle done pulse. A successful operation also presents updated destination coordinates for the register file to take in.

Top module: `blit2d_engine`

## Requirements
- R1: The pixel width comes from `fmt[3:0]`. Code 2 gives 1 byte per pixel, 3 or 4 give 2 bytes, 5 gives 3 bytes and 6 gives 4 bytes. Any other code raises `err` and writes nothing.
- R2: Each axis has a direction bit. When `x_ltr` is 1 the start X is the register value. When it is 0 the start X is the register value + 1 − `rect_w`, computed modulo 2^16. `y_ttb` with `rect_h` sets the start Y by the same rule. The rule applies to source and destination alike.
- R3: When `sep_regs` is 1, the source uses its own pitch and base and the destination uses its own pitch and base. When `sep_regs` is 0, `def_pitch` and `def_base` are used for both.
- R4: An operation is rejected, raising `err` and writing nothing, in any of these cases:
  - a start coordinate it uses exceeds 0x3FFF;
  - a selected pitch is zero;
  - the base is at or past the end of memory;
  - base + startX + (startY + height) × pitch reaches the end of memory;
  - the last byte the rectangle touches lies past the end of memory.
- R5: `rop` picks the operation:
  - 0xCC copies the source rectangle;
  - 0xF0 fills with `brush_color`;
  - 0x00 fills with {0xFF, `pal_black`};
  - 0xFF fills with {0xFF, `pal_white`};
  - any other value raises `err` and writes nothing.
- R6: On a reversed axis the engine walks from the far end of that axis. A copy whose destination is displaced from its source in the reversed direction therefore ends equal to a copy that reads the whole source first.
- R7: After a successful copy, both `wb_x_en` and `wb_y_en` pulse with `done`. `wb_x` is startX + width when `x_ltr` is 1, and startX when it is 0. `wb_y` follows the same rule with height and `y_ttb`.
- R8: After a successful fill, only `wb_y_en` pulses, and `wb_y` follows the rule of R7. `wb_x_en` stays 0.
- R9: When `pix_pitch_mode` is 1, the selected pitch counts pixels and is multiplied by the bytes per pixel. In this mode bits 26:0 of `disp_start` are also added to both bases.
- R10: Timing of the status outputs:
  - `busy` is 1 from the cycle after `start` through the cycle of `done`;
  - `done` lasts exactly one cycle;
  - `err` is set for a rejected operation and holds until the next start.
- R11: A pixel byte k lives at byte address base + y × pitch + x × bytesPerPixel + k. Bytes are packed little-endian in 32-bit words, word address = byte address / 4. Every write enables exactly one byte lane, and a read is never issued in the same cycle as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins an operation while idle |
| x_ltr | input | 1 | 1: X runs left to right |
| y_ttb | input | 1 | 1: Y runs top to bottom |
| sep_regs | input | 1 | 1: separate source/destination pitch and base |
| pix_pitch_mode | input | 1 | 1: pitch in pixels, display start added to bases |
| fmt | input | 4 | Pixel format code |
| rop | input | 8 | Raster operation code |
| src_x | input | CW | Source X register |
| src_y | input | CW | Source Y register |
| dst_x | input | CW | Destination X register |
| dst_y | input | CW | Destination Y register |
| rect_w | input | CW | Width in pixels |
| rect_h | input | CW | Height in rows |
| src_pitch | input | CW | Source pitch |
| dst_pitch | input | CW | Destination pitch |
| def_pitch | input | CW | Shared pitch |
| src_base | input | 32 | Source base byte address |
| dst_base | input | 32 | Destination base byte address |
| def_base | input | 32 | Shared base byte address |
| disp_start | input | 32 | Display start offset for pixel-pitch mode |
| brush_color | input | 32 | Pattern fill colour |
| pal_black | input | 24 | Palette entry used by the black fill |
| pal_white | input | 24 | Palette entry used by the white fill |
| mem_rd | output | 1 | Word read request |
| mem_wr | output | 1 | Word write request |
| mem_addr | output | WAW | Word address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation was rejected |
| wb_x | output | CW | New destination X |
| wb_y | output | CW | New destination Y |
| wb_x_en | output | 1 | Load `wb_x` into the X register |
| wb_y_en | output | 1 | Load `wb_y` into the Y register |

## Verification
The checks assume the following about the block's inputs:
- the operation fields stay constant from `start` until `done`;
- `rst_n` is low at time zero;
- the memory answers a read in the following cycle.

The stimulus follows these assumptions. Each scenario task sets all fields before a single-cycle start pulse, holds them until the done pulse has been seen, and uses a memory model that registers read data on the request edge. Overlapping copies are only driven with the destination displaced in the reversed direction, which is the case the far-corner walk is specified to cover.

// File: rtl/blit2d_pkg.sv
// Shared codes and types for the rectangle engine.
// Assumes byte-serial processing and one-cycle read latency.
package blit2d_pkg;

    localparam logic [7:0] ROP_SRC_COPY = 8'hCC;
    localparam logic [7:0] ROP_PAT_FILL = 8'hF0;
    localparam logic [7:0] ROP_BLACK    = 8'h00;
    localparam logic [7:0] ROP_WHITE    = 8'hFF;

    typedef enum logic [1:0] {OP_NONE, OP_COPY, OP_FILL} op_e;

    typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_RWAIT, ST_WR, ST_FIN} state_e;

    // Bytes per pixel for a format code, 0 when the code is invalid.
    function automatic logic [2:0] fmt_bytes(input logic [3:0] code);
        case (code)
            4'd2:       fmt_bytes = 3'd1;
            4'd3, 4'd4: fmt_bytes = 3'd2;
            4'd5:       fmt_bytes = 3'd3;
            4'd6:       fmt_bytes = 3'd4;
            default:    fmt_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/blit2d_setup.sv
// Combinational decode of one operation. It works out:
//   - the pixel size and the operation kind;
//   - the start corners of source and destination;
//   - the effective pitch and base of each;
//   - the fill colour;
//   - whether the operation must be rejected.
// Assumes every input is held steady while the engine is busy.
module blit2d_setup
    import blit2d_pkg::*;
#(
    parameter int CW        = 16,
    parameter int MEM_BYTES = 4096
) (
    input  logic          x_ltr,
    input  logic          y_ttb,
    input  logic          sep_regs,
    input  logic          pix_pitch_mode,
    input  logic [3:0]    fmt,
    input  logic [7:0]    rop,
    input  logic [CW-1:0] src_x,
    input  logic [CW-1:0] src_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic [CW-1:0] rect_w,
    input  logic [CW-1:0] rect_h,
    input  logic [CW-1:0] src_pitch,
    input  logic [CW-1:0] dst_pitch,
    input  logic [CW-1:0] def_pitch,
    input  logic [31:0]   src_base,
    input  logic [31:0]   dst_base,
    input  logic [31:0]   def_base,
    input  logic [31:0]   disp_start,
    input  logic [31:0]   brush_color,
    input  logic [23:0]   pal_black,
    input  logic [23:0]   pal_white,
    output logic [2:0]    bpb,
    output op_e           op,
    output logic          reject,
    output logic [CW-1:0] sx0,
    output logic [CW-1:0] sy0,
    output logic [CW-1:0] dx0,
    output logic [CW-1:0] dy0,
    output logic [31:0]   spitch_e,
    output logic [31:0]   dpitch_e,
    output logic [31:0]   sbase_e,
    output logic [31:0]   dbase_e,
    output logic [31:0]   fill_color
);

    localparam logic [CW-1:0] COORD_MAX = CW'(16'h3FFF);
    localparam logic [47:0]   MEMB      = 48'(MEM_BYTES);

    logic [CW-1:0] sp_raw, dp_raw;
    logic [31:0]   sb_raw, db_raw, disp_add;
    logic          src_bad, dst_bad;

    // True when a rectangle at this corner would break a range rule.
    function automatic logic span_bad(input logic [31:0] base, input logic [31:0] pitch,
                                      input logic [CW-1:0] x0, input logic [CW-1:0] y0,
                                      input logic [CW-1:0] w, input logic [CW-1:0] h,
                                      input logic [2:0] nb);
        logic [47:0] b, p, x, y, ww, hh, row_end, last_end;
        b  = 48'(base);
        p  = 48'(pitch);
        x  = 48'(x0);
        y  = 48'(y0);
        ww = 48'(w);
        hh = 48'(h);
        row_end  = b + x + (y + hh) * p;
        last_end = b + (y + hh - 48'd1) * p + (x + ww) * 48'(nb);
        span_bad = (x0 > COORD_MAX) || (y0 > COORD_MAX) || (b >= MEMB) ||
                   (row_end >= MEMB) || ((w != '0) && (h != '0) && (last_end > MEMB));
    endfunction

    // Pixel size and operation kind.
    always_comb begin
        bpb = fmt_bytes(fmt);
        case (rop)
            ROP_SRC_COPY:                       op = OP_COPY;
            ROP_PAT_FILL, ROP_BLACK, ROP_WHITE: op = OP_FILL;
            default:                            op = OP_NONE;
        endcase
    end

    // Start corners follow the per-axis direction bits.
    always_comb begin
        sx0 = x_ltr ? src_x : src_x + CW'(1) - rect_w;
        dx0 = x_ltr ? dst_x : dst_x + CW'(1) - rect_w;
        sy0 = y_ttb ? src_y : src_y + CW'(1) - rect_h;
        dy0 = y_ttb ? dst_y : dst_y + CW'(1) - rect_h;
    end

    // Pitch and base selection, including the pixel-pitch mode.
    always_comb begin
        sp_raw   = sep_regs ? src_pitch : def_pitch;
        dp_raw   = sep_regs ? dst_pitch : def_pitch;
        sb_raw   = sep_regs ? src_base : def_base;
        db_raw   = sep_regs ? dst_base : def_base;
        disp_add = pix_pitch_mode ? (disp_start & 32'h07FF_FFFF) : 32'd0;
        spitch_e = pix_pitch_mode ? 32'(sp_raw) * 32'(bpb) : 32'(sp_raw);
        dpitch_e = pix_pitch_mode ? 32'(dp_raw) * 32'(bpb) : 32'(dp_raw);
        sbase_e  = sb_raw + disp_add;
        dbase_e  = db_raw + disp_add;
    end

    // Fill colour selection, forcing alpha on the palette fills.
    always_comb begin
        case (rop)
            ROP_BLACK: fill_color = {8'hFF, pal_black};
            ROP_WHITE: fill_color = {8'hFF, pal_white};
            default:   fill_color = brush_color;
        endcase
    end

    // Range and validity checks.
    always_comb begin
        dst_bad = span_bad(dbase_e, dpitch_e, dx0, dy0, rect_w, rect_h, bpb);
        src_bad = span_bad(sbase_e, spitch_e, sx0, sy0, rect_w, rect_h, bpb);
        reject  = (bpb == 3'd0) || (op == OP_NONE) || (dp_raw == '0) || dst_bad ||
                  ((op == OP_COPY) && ((sp_raw == '0) || src_bad));
    end

endmodule

// File: rtl/blit2d_walker.sv
// Walks the rectangle one byte at a time and produces the source and
// destination byte addresses. On a reversed axis it starts from the far end.
// Assumes bpb is between 1 and 4 and that width and height are non-zero
// while stepping.
module blit2d_walker #(
    parameter int CW = 16,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic          x_ltr,
    input  logic          y_ttb,
    input  logic [2:0]    bpb,
    input  logic [CW-1:0] rect_w,
    input  logic [CW-1:0] rect_h,
    input  logic [CW-1:0] sx0,
    input  logic [CW-1:0] sy0,
    input  logic [CW-1:0] dx0,
    input  logic [CW-1:0] dy0,
    input  logic [31:0]   spitch,
    input  logic [31:0]   dpitch,
    input  logic [31:0]   sbase,
    input  logic [31:0]   dbase,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [1:0]    kk,
    output logic          last
);

    logic [CW-1:0] row, pix, px, py;
    logic [1:0]    k;
    logic [2:0]    bm1;

    assign bm1 = bpb - 3'd1;

    // Byte, pixel and row counters, advanced once per written byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            row <= '0;
            pix <= '0;
            k   <= '0;
        end else if (step) begin
            if (k != bm1[1:0]) begin
                k <= k + 2'd1;
            end else begin
                k <= '0;
                if (pix != rect_w - CW'(1)) begin
                    pix <= pix + CW'(1);
                end else begin
                    pix <= '0;
                    row <= row + CW'(1);
                end
            end
        end
    end

    // Map counters to positions, mirrored on reversed axes.
    always_comb begin
        kk   = x_ltr ? k : bm1[1:0] - k;
        px   = x_ltr ? pix : rect_w - CW'(1) - pix;
        py   = y_ttb ? row : rect_h - CW'(1) - row;
        last = (k == bm1[1:0]) && (pix == rect_w - CW'(1)) && (row == rect_h - CW'(1));
    end

    // Byte addresses of the current byte.
    assign src_addr = AW'(sbase + (32'(sy0) + 32'(py)) * spitch +
                          (32'(sx0) + 32'(px)) * 32'(bpb) + 32'(kk));
    assign dst_addr = AW'(dbase + (32'(dy0) + 32'(py)) * dpitch +
                          (32'(dx0) + 32'(px)) * 32'(bpb) + 32'(kk));

endmodule

// File: rtl/blit2d_engine.sv
// Top of the rectangle engine. It sequences one copy or fill per start pulse
// and moves one byte per write through the word port. It also reports busy,
// done and err, and presents the destination coordinate write-back.
// Assumes the input fields stay steady from start to done and that read
// data arrives one cycle after mem_rd.
module blit2d_engine
    import blit2d_pkg::*;
#(
    parameter int CW        = 16,
    parameter int MEM_BYTES = 4096,
    parameter int MEM_WORDS = MEM_BYTES / 4,
    parameter int WAW       = $clog2(MEM_WORDS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           x_ltr,
    input  logic           y_ttb,
    input  logic           sep_regs,
    input  logic           pix_pitch_mode,
    input  logic [3:0]     fmt,
    input  logic [7:0]     rop,
    input  logic [CW-1:0]  src_x,
    input  logic [CW-1:0]  src_y,
    input  logic [CW-1:0]  dst_x,
    input  logic [CW-1:0]  dst_y,
    input  logic [CW-1:0]  rect_w,
    input  logic [CW-1:0]  rect_h,
    input  logic [CW-1:0]  src_pitch,
    input  logic [CW-1:0]  dst_pitch,
    input  logic [CW-1:0]  def_pitch,
    input  logic [31:0]    src_base,
    input  logic [31:0]    dst_base,
    input  logic [31:0]    def_base,
    input  logic [31:0]    disp_start,
    input  logic [31:0]    brush_color,
    input  logic [23:0]    pal_black,
    input  logic [23:0]    pal_white,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic [WAW-1:0] mem_addr,
    output logic [3:0]     mem_be,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    output logic           busy,
    output logic           done,
    output logic           err,
    output logic [CW-1:0]  wb_x,
    output logic [CW-1:0]  wb_y,
    output logic           wb_x_en,
    output logic           wb_y_en
);

    localparam int AW = WAW + 2;

    state_e        state;
    op_e           op;
    logic [2:0]    bpb;
    logic          reject, err_q, last, empty, launch;
    logic [CW-1:0] sx0, sy0, dx0, dy0;
    logic [31:0]   spitch_e, dpitch_e, sbase_e, dbase_e, fill_color;
    logic [AW-1:0] src_addr, dst_addr;
    logic [1:0]    kk;
    logic [7:0]    rbyte, wbyte;

    blit2d_setup #(.CW(CW), .MEM_BYTES(MEM_BYTES)) u_setup (
        .x_ltr(x_ltr), .y_ttb(y_ttb), .sep_regs(sep_regs),
        .pix_pitch_mode(pix_pitch_mode), .fmt(fmt), .rop(rop),
        .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .rect_w(rect_w), .rect_h(rect_h),
        .src_pitch(src_pitch), .dst_pitch(dst_pitch), .def_pitch(def_pitch),
        .src_base(src_base), .dst_base(dst_base), .def_base(def_base),
        .disp_start(disp_start), .brush_color(brush_color),
        .pal_black(pal_black), .pal_white(pal_white),
        .bpb(bpb), .op(op), .reject(reject),
        .sx0(sx0), .sy0(sy0), .dx0(dx0), .dy0(dy0),
        .spitch_e(spitch_e), .dpitch_e(dpitch_e),
        .sbase_e(sbase_e), .dbase_e(dbase_e), .fill_color(fill_color)
    );

    assign launch = (state == ST_IDLE) && start;
    assign empty  = (rect_w == '0) || (rect_h == '0);

    blit2d_walker #(.CW(CW), .AW(AW)) u_walk (
        .clk(clk), .rst_n(rst_n), .clr(launch), .step(state == ST_WR),
        .x_ltr(x_ltr), .y_ttb(y_ttb), .bpb(bpb),
        .rect_w(rect_w), .rect_h(rect_h),
        .sx0(sx0), .sy0(sy0), .dx0(dx0), .dy0(dy0),
        .spitch(spitch_e), .dpitch(dpitch_e), .sbase(sbase_e), .dbase(dbase_e),
        .src_addr(src_addr), .dst_addr(dst_addr), .kk(kk), .last(last)
    );

    // Operation sequencer, error flag and read-byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            err_q <= 1'b0;
            rbyte <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    err_q <= reject;
                    if (reject || empty) state <= ST_FIN;
                    else if (op == OP_COPY) state <= ST_RD;
                    else state <= ST_WR;
                end
                ST_RD:    state <= ST_RWAIT;
                ST_RWAIT: begin
                    rbyte <= 8'(mem_rdata >> {src_addr[1:0], 3'b000});
                    state <= ST_WR;
                end
                ST_WR: begin
                    if (last) state <= ST_FIN;
                    else if (op == OP_COPY) state <= ST_RD;
                    else state <= ST_WR;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive: one byte lane per write.
    always_comb begin
        wbyte     = (op == OP_COPY) ? rbyte : 8'(fill_color >> {kk, 3'b000});
        mem_rd    = (state == ST_RD);
        mem_wr    = (state == ST_WR);
        mem_addr  = (state == ST_RD) ? src_addr[AW-1:2] : dst_addr[AW-1:2];
        mem_be    = 4'b0001 << dst_addr[1:0];
        mem_wdata = {4{wbyte}};
    end

    // Status and coordinate write-back.
    always_comb begin
        busy    = (state != ST_IDLE);
        done    = (state == ST_FIN);
        err     = err_q;
        wb_x    = x_ltr ? dx0 + rect_w : dx0;
        wb_y    = y_ttb ? dy0 + rect_h : dy0;
        wb_x_en = done && !err_q && (op == OP_COPY);
        wb_y_en = done && !err_q;
    end

endmodule

// File: rtl/blit2d_checker.sv
// Property checks for blit2d_engine, attached by bind below.
// Assumes rst_n is low at time zero.
module blit2d_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic [3:0] mem_be,
    input logic       wb_x_en,
    input logic       wb_y_en
);

    p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_one_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($countones(mem_be) == 1));

    p_no_write_on_error_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_wr);

    p_read_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !mem_wr));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_wb_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_x_en || wb_y_en) |-> done);

    p_x_needs_y_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_x_en |-> wb_y_en);

endmodule

bind blit2d_engine blit2d_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .err(err), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_be(mem_be),
    .wb_x_en(wb_x_en), .wb_y_en(wb_y_en)
);

// File: tb/blit2d_engine_tb.sv
// Directed bench: one task per scenario, each checking its own results
// against a byte-level reference model of the frame buffer.
module blit2d_engine_tb;

    localparam int MB = 4096;
    localparam int MW = MB / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic x_ltr, y_ttb, sep_regs, pix_pitch_mode;
    logic [3:0] fmt;
    logic [7:0] rop;
    logic [15:0] src_x, src_y, dst_x, dst_y, rect_w, rect_h;
    logic [15:0] src_pitch, dst_pitch, def_pitch;
    logic [31:0] src_base, dst_base, def_base, disp_start, brush_color;
    logic [23:0] pal_black, pal_white;
    logic mem_rd, mem_wr, busy, done, err, wb_x_en, wb_y_en;
    logic [9:0] mem_addr;
    logic [3:0] mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [15:0] wb_x, wb_y;

    logic [31:0] mem [0:MW-1];
    logic [7:0]  eb  [0:MB-1];

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic g_err, g_xen, g_yen;
    logic [15:0] g_wbx, g_wby;

    always #5 clk = ~clk;

    blit2d_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .x_ltr(x_ltr), .y_ttb(y_ttb),
        .sep_regs(sep_regs), .pix_pitch_mode(pix_pitch_mode), .fmt(fmt), .rop(rop),
        .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .rect_w(rect_w), .rect_h(rect_h), .src_pitch(src_pitch),
        .dst_pitch(dst_pitch), .def_pitch(def_pitch), .src_base(src_base),
        .dst_base(dst_base), .def_base(def_base), .disp_start(disp_start),
        .brush_color(brush_color), .pal_black(pal_black), .pal_white(pal_white),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .err(err), .wb_x(wb_x), .wb_y(wb_y), .wb_x_en(wb_x_en), .wb_y_en(wb_y_en)
    );

    // Frame buffer model: byte-lane writes, reads registered one cycle.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_wr)
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) mem[mem_addr][8*l +: 8] <= mem_wdata[8*l +: 8];
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int j = 0; j < MB; j++) eb[j] = 8'((j * 7 + 3) ^ (j >> 8));
        for (int w = 0; w < MW; w++) mem[w] = {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]};
    endtask

    task automatic cmp_mem(input string tag);
        int nbad = 0;
        logic [31:0] fa = '0, fe = '0;
        for (int w = 0; w < MW; w++) begin
            logic [31:0] e;
            e = {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]};
            if (mem[w] !== e) begin
                if (nbad == 0) begin fa = mem[w]; fe = e; end
                nbad++;
            end
        end
        chk(nbad == 0, tag, 64'(fa), 64'(fe));
    endtask

    task automatic defaults();
        x_ltr = 1; y_ttb = 1; sep_regs = 1; pix_pitch_mode = 0;
        fmt = 4'd6; rop = 8'hF0;
        src_x = 0; src_y = 0; dst_x = 0; dst_y = 0; rect_w = 1; rect_h = 1;
        src_pitch = 16; dst_pitch = 16; def_pitch = 16;
        src_base = 0; dst_base = 0; def_base = 0; disp_start = 0;
        brush_color = 0; pal_black = 0; pal_white = 0;
    endtask

    task automatic ref_fill(int db, int dp, int dx, int dy, int w, int h, int nb,
                            logic [31:0] col);
        for (int r = 0; r < h; r++)
            for (int p = 0; p < w; p++)
                for (int k = 0; k < nb; k++)
                    eb[db + (dy + r) * dp + (dx + p) * nb + k] = col[8*k +: 8];
    endtask

    task automatic ref_copy(int sb, int sp, int sx, int sy, int db, int dp, int dx,
                            int dy, int w, int h, int nb);
        logic [7:0] tmp [0:1023];
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w * nb; c++)
                tmp[r * w * nb + c] = eb[sb + (sy + r) * sp + sx * nb + c];
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w * nb; c++)
                eb[db + (dy + r) * dp + dx * nb + c] = tmp[r * w * nb + c];
    endtask

    // Start pulse, then check busy/err timing and capture write-back (R10).
    task automatic run_op(input string tag, input logic exp_err);
        int n = 0;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        chk(busy == 1'b1, {tag, " R10 busy after start"}, 64'(busy), 64'd1);
        chk(err == exp_err, {tag, " R10 err after start"}, 64'(err), 64'(exp_err));
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(done == 1'b1, {tag, " R10 done seen"}, 64'(done), 64'd1);
        g_err = err; g_xen = wb_x_en; g_yen = wb_y_en; g_wbx = wb_x; g_wby = wb_y;
        @(negedge clk);
        chk(!done && !busy, {tag, " R10 done one cycle"}, 64'({done, busy}), 64'd0);
        chk(err == g_err, {tag, " R10 err held"}, 64'(err), 64'(g_err));
    endtask

    task automatic t_reset();
        chk(!busy && !done && !err && !mem_wr && !mem_rd, "R10 reset state",
            64'({busy, done, err, mem_wr, mem_rd}), 64'd0);
    endtask

    task automatic t_fill32();
        defaults(); init_mem();
        rop = 8'hF0; brush_color = 32'h1122_3344; dst_base = 32'h100; dst_pitch = 64;
        def_pitch = 0; dst_x = 2; dst_y = 1; rect_w = 3; rect_h = 2;
        run_op("fill32", 1'b0);
        ref_fill(32'h100, 64, 2, 1, 3, 2, 4, 32'h1122_3344);
        cmp_mem("R5 R3 R11 brush fill 32bpp");
        chk(!g_err && !g_xen && g_yen && g_wby == 16'd3, "R8 fill write-back",
            64'({g_err, g_xen, g_yen, g_wby}), 64'({3'b001, 16'd3}));
    endtask

    task automatic t_black8();
        defaults(); init_mem();
        fmt = 4'd2; rop = 8'h00; pal_black = 24'h0000AB; sep_regs = 0;
        def_base = 32'h200; def_pitch = 16; dst_pitch = 0;
        dst_x = 5; dst_y = 2; rect_w = 3; rect_h = 2;
        run_op("black8", 1'b0);
        ref_fill(32'h200, 16, 5, 2, 3, 2, 1, 32'hFF00_00AB);
        cmp_mem("R1 R3 R5 black fill 8bpp shared pitch");
        chk(g_yen && g_wby == 16'd4, "R8 black fill y", 64'(g_wby), 64'd4);
    endtask

    task automatic t_white();
        defaults(); init_mem();
        rop = 8'hFF; pal_white = 24'h123456; dst_base = 32'h300; dst_pitch = 32;
        x_ltr = 0; y_ttb = 0; dst_x = 1; dst_y = 0; rect_w = 2; rect_h = 1;
        run_op("white32", 1'b0);
        ref_fill(32'h300, 32, 0, 0, 2, 1, 4, 32'hFF12_3456);
        cmp_mem("R5 R2 white fill 32bpp alpha forced");
        chk(!g_xen && g_yen && g_wby == 16'd0, "R8 reversed fill y",
            64'({g_xen, g_wby}), 64'd0);
        init_mem();
        fmt = 4'd5; x_ltr = 1; y_ttb = 1; dst_base = 32'h340; dst_pitch = 16;
        dst_x = 1; rect_w = 2;
        run_op("white24", 1'b0);
        ref_fill(32'h340, 16, 1, 0, 2, 1, 3, 32'hFF12_3456);
        cmp_mem("R1 R11 white fill 24bpp straddling words");
    endtask

    task automatic t_copy16();
        defaults(); init_mem();
        fmt = 4'd3; rop = 8'hCC; src_base = 32'h400; src_pitch = 32;
        dst_base = 32'h600; dst_pitch = 32; src_x = 1; src_y = 1;
        dst_x = 2; dst_y = 3; rect_w = 4; rect_h = 3;
        run_op("copy16", 1'b0);
        ref_copy(32'h400, 32, 1, 1, 32'h600, 32, 2, 3, 4, 3, 2);
        cmp_mem("R5 R11 forward copy 16bpp");
        chk(g_xen && g_yen && g_wbx == 16'd6 && g_wby == 16'd6, "R7 copy write-back",
            64'({g_xen, g_yen, g_wbx, g_wby}), 64'({2'b11, 16'd6, 16'd6}));
    endtask

    task automatic t_rev_x();
        defaults(); init_mem();
        fmt = 4'd4; rop = 8'hCC; sep_regs = 0; def_base = 32'h800; def_pitch = 32;
        x_ltr = 0; src_x = 4; dst_x = 5; rect_w = 4; rect_h = 2;
        run_op("revx", 1'b0);
        ref_copy(32'h800, 32, 1, 0, 32'h800, 32, 2, 0, 4, 2, 2);
        cmp_mem("R6 R2 overlapping copy, X reversed");
        chk(g_wbx == 16'd2 && g_wby == 16'd2, "R7 reversed-x write-back",
            64'({g_wbx, g_wby}), 64'({16'd2, 16'd2}));
    endtask

    task automatic t_rev_y();
        defaults(); init_mem();
        rop = 8'hCC; sep_regs = 0; def_base = 32'hA00; def_pitch = 16;
        y_ttb = 0; src_x = 1; dst_x = 1; src_y = 2; dst_y = 3; rect_w = 2; rect_h = 3;
        run_op("revy", 1'b0);
        ref_copy(32'hA00, 16, 1, 0, 32'hA00, 16, 1, 1, 2, 3, 4);
        cmp_mem("R6 R2 overlapping copy, Y reversed");
        chk(g_wbx == 16'd3 && g_wby == 16'd1, "R7 reversed-y write-back",
            64'({g_wbx, g_wby}), 64'({16'd3, 16'd1}));
    endtask

    task automatic t_reject(input string tag);
        run_op(tag, 1'b1);
        cmp_mem({tag, " memory untouched"});
        chk(g_err && !g_xen && !g_yen, {tag, " err without write-back"},
            64'({g_err, g_xen, g_yen}), 64'b100);
    endtask

    task automatic t_rejects();
        defaults(); init_mem(); dst_base = 32'h100; rect_w = 2; rect_h = 2;
        fmt = 4'd7;                          t_reject("R1 bad format");
        fmt = 4'd6; rop = 8'h66;             t_reject("R5 unsupported rop");
        rop = 8'hF0; dst_pitch = 0;          t_reject("R4 zero dst pitch");
        dst_pitch = 16; x_ltr = 0; dst_x = 0; t_reject("R4 R2 coord above limit");
        x_ltr = 1; dst_base = 32'hF00; dst_pitch = 256; t_reject("R4 past end of memory");
        dst_base = 32'h100; dst_pitch = 16; rop = 8'hCC; src_pitch = 0;
        t_reject("R4 zero src pitch");
        src_pitch = 16; dst_x = 16'h4000;    t_reject("R4 dst x above 0x3FFF");
    endtask

    task automatic t_pixpitch();
        defaults(); init_mem();
        pix_pitch_mode = 1; fmt = 4'd3; rop = 8'hF0; brush_color = 32'h0000_BEEF;
        dst_pitch = 8; dst_base = 32'h100; disp_start = 32'hF800_0C00;
        dst_x = 1; dst_y = 1; rect_w = 2; rect_h = 2;
        run_op("pixpitch", 1'b0);
        ref_fill(32'hD00, 16, 1, 1, 2, 2, 2, 32'h0000_BEEF);
        cmp_mem("R9 pixel pitch and display start");
    endtask

    initial begin
        defaults();
        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fill32();
        t_black8();
        t_white();
        t_copy16();
        t_rev_x();
        t_rev_y();
        t_rejects();
        t_fill32();
        t_pixpitch();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        wait (cycles > 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule